// File: doc/BRIEF.md
# Link-Layer Packet Replay Buffer

This block sits on the transmit side of a link layer, between the transaction layer and the framing logic. Each outgoing transaction packet is accepted on a valid/ready input and given the next 12-bit sequence number. It leaves on the same cycle with that number and a freshly computed 32-bit link CRC, and a copy of its body is kept in a replay store.

The far end reports back through a single event input, which carries a sequence number and a flag that selects acknowledge or negative acknowledge. An acknowledge frees every stored packet up to and including the reported number. A negative acknowledge frees up to the reported number and then resends every remaining packet, oldest first. A replay timer resends the same set when no progress is seen for a programmable number of cycles. Resent packets are read back from the store, and their CRC is generated again on the way out.

Each packet is one beat of `DATA_W` bits. The store holds `DEPTH` packets, where `DEPTH` is a power of two and no more than 4096.

Top module: `tlp_replay_buf`

## Requirements
- R1: Sequence numbers are 12 bits wide. The first packet after reset gets 0, each newly accepted packet gets the previous one plus 1, and the number after 4095 is 0.
- R2: A newly accepted packet appears on the output in the same cycle it is accepted, with its own body. `inReady` is never high while `outReady` is low.
- R3: `outCrc` is a CRC-32 with polynomial 0x04C11DB7 and an all-ones seed. It is computed MSB first over a 16-bit field {4'b0000, sequence} followed by the body MSB first, and the final value is bitwise inverted. The same rule holds for first transmissions and for replays.
- R4: An acknowledge with sequence n inside the window frees every outstanding packet up to and including n, using modulo-4096 arithmetic. The freed slots become available for new packets.
- R5: A negative acknowledge with sequence n inside the window frees up to and including n, then resends every packet still outstanding. Replays go oldest first, with their original sequence numbers and bodies, and the output holds steady while `outReady` is low.
- R6: When packets are outstanding and no replay is running, the timer restarts on each new send and on each acknowledge that frees packets. If `TIMEOUT` cycles pass with neither event, all outstanding packets are replayed, starting on the cycle `TIMEOUT` edges after the last restart.
- R7: `inReady` is low while `DEPTH` packets are outstanding and while a replay is in progress.
- R8: An event is ignored when its distance d = (n - last acknowledged) mod 4096 falls outside the window. For an acknowledge the window is 1..outstanding; for a negative acknowledge it is 0..outstanding.
- R9: With nothing outstanding the timer is stopped, so no replay ever starts.
- R10: After reset nothing is outstanding, `outValid` is low and `inReady` equals `outReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | New packet offered |
| inReady | output | 1 | New packet accepted this cycle when high with inValid |
| inBody | input | DATA_W | New packet body |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Downstream takes the output beat |
| outSeq | output | 12 | Sequence number of the output beat |
| outBody | output | DATA_W | Body of the output beat |
| outCrc | output | 32 | Link CRC of the output beat |
| evtValid | input | 1 | Acknowledge or negative-acknowledge event |
| evtNak | input | 1 | 1 selects negative acknowledge, 0 acknowledge |
| evtSeq | input | 12 | Sequence number carried by the event |

## Verification
The assertions take for granted that only one event arrives per cycle. They also assume the packet source keeps `inValid` and `inBody` steady until `inReady` is seen, and that stepping and holding checks on the replay output apply only on cycles without an event, since an event may legally move the replay pointer. The stimulus drives every event and packet at the falling edge and holds a packet until it is taken. It issues one event at a time, and it stalls the output only on cycles with no event, so it never breaks these assumptions.

// File: rtl/tlp_replay_pkg.sv
package tlp_replay_pkg;
  localparam int SEQ_W = 12;
  localparam int SEQ_FIELD_W = 16;
  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;

  typedef logic [SEQ_W-1:0] seq_t;

  // strobes from control to datapath
  typedef struct packed {
    logic storeWr;    // write inBody into the slot of txSeq
    logic replaySel;  // output body comes from the store
    seq_t txSeq;      // sequence number on the output this cycle
  } strobe_t;
endpackage

// File: rtl/tlp_replay_dp.sv
module tlp_replay_dp
  import tlp_replay_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] inBody,
  output logic [DATA_W-1:0] outBody,
  output seq_t              outSeq,
  output logic [CRC_W-1:0]  outCrc
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int MSG_W = SEQ_FIELD_W + DATA_W;

  logic [DATA_W-1:0] store [DEPTH];
  logic [IDX_W-1:0]  slot;
  logic [MSG_W-1:0]  msg;
  logic [CRC_W-1:0]  crcReg;
  logic              feedBit;

  assign slot = strobe.txSeq[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (strobe.storeWr) store[slot] <= inBody;
  end

  assign outBody = strobe.replaySel ? store[slot] : inBody;
  assign outSeq  = strobe.txSeq;
  assign msg     = {{(SEQ_FIELD_W-SEQ_W){1'b0}}, strobe.txSeq, outBody};

  // serial CRC unrolled over the message, most significant bit first
  always_comb begin
    crcReg = '1;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      feedBit = crcReg[CRC_W-1] ^ msg[i];
      crcReg  = {crcReg[CRC_W-2:0], 1'b0} ^ (feedBit ? CRC_POLY : '0);
    end
    outCrc = ~crcReg;
  end
endmodule

// File: rtl/tlp_replay_ctrl.sv
module tlp_replay_ctrl
  import tlp_replay_pkg::*;
#(
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  input  logic    evtValid,
  input  logic    evtNak,
  input  seq_t    evtSeq,
  output logic    inReady,
  output logic    outValid,
  output logic    replayOn,
  output strobe_t strobe
);
  localparam int   TMR_W   = $clog2(TIMEOUT + 1);
  localparam seq_t DEPTH_S = seq_t'(DEPTH);
  localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(TIMEOUT - 1);

  seq_t nextSeq, ackedSeq, replaySeq;
  logic replaying;
  logic [TMR_W-1:0] timer;

  seq_t count, evtDist, ackedNext, nextSeqN, repBase, repPos, remaining;
  seq_t replaySeqN;
  logic full, newSend, repSend, ackOk, nakOk, progress, timeout, startRep;
  logic replayingN;

  always_comb begin
    count   = nextSeq - ackedSeq - 1'b1;
    full    = (count == DEPTH_S);
    inReady = !replaying && !full && outReady;
    outValid = replaying || (inValid && !full);
    newSend = inValid && inReady;
    repSend = replaying && outReady;

    evtDist = evtSeq - ackedSeq;
    ackOk   = evtValid && !evtNak && (evtDist != '0) && (evtDist <= count);
    nakOk   = evtValid && evtNak && (evtDist <= count);
    ackedNext = (ackOk || nakOk) ? evtSeq : ackedSeq;
    progress  = ackOk || (nakOk && (evtDist != '0));
    nextSeqN  = nextSeq + seq_t'(newSend);
    remaining = nextSeqN - ackedNext - 1'b1;

    // replay pointer: step on a taken beat, skip past newly acked packets
    repBase = replaySeq + seq_t'(repSend);
    repPos  = repBase - ackedSeq - 1'b1;
    if (replaying && ackOk && (evtDist > repPos)) repBase = evtSeq + 1'b1;

    timeout  = !replaying && (count != '0) && (timer == TMR_LAST)
               && !newSend && !progress;
    startRep = (nakOk && (remaining != '0)) || timeout;

    if (startRep) begin
      replayingN = 1'b1;
      replaySeqN = ackedNext + 1'b1;
    end else if (replaying) begin
      replayingN = (repBase != nextSeqN);
      replaySeqN = repBase;
    end else begin
      replayingN = 1'b0;
      replaySeqN = replaySeq;
    end

    strobe.storeWr   = newSend;
    strobe.replaySel = replaying;
    strobe.txSeq     = replaying ? replaySeq : nextSeq;
  end

  assign replayOn = replaying;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nextSeq   <= '0;
      ackedSeq  <= '1;
      replaySeq <= '0;
      replaying <= 1'b0;
      timer     <= '0;
    end else begin
      nextSeq   <= nextSeqN;
      ackedSeq  <= ackedNext;
      replaySeq <= replaySeqN;
      replaying <= replayingN;
      if ((remaining == '0) || replaying || newSend || progress || timeout)
        timer <= '0;
      else
        timer <= timer + 1'b1;
    end
  end
endmodule

// File: rtl/tlp_replay_buf.sv
module tlp_replay_buf
  import tlp_replay_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int DEPTH   = 8,
  parameter int TIMEOUT = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inBody,
  output logic              outValid,
  input  logic              outReady,
  output logic [11:0]       outSeq,
  output logic [DATA_W-1:0] outBody,
  output logic [31:0]       outCrc,
  input  logic              evtValid,
  input  logic              evtNak,
  input  logic [11:0]       evtSeq
);
  strobe_t strobe;
  logic    replayOn;

  tlp_replay_ctrl #(.DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .outReady(outReady),
    .evtValid(evtValid), .evtNak(evtNak), .evtSeq(evtSeq),
    .inReady(inReady), .outValid(outValid), .replayOn(replayOn),
    .strobe(strobe)
  );

  tlp_replay_dp #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDp (
    .clk(clk), .strobe(strobe), .inBody(inBody),
    .outBody(outBody), .outSeq(outSeq), .outCrc(outCrc)
  );
endmodule

// File: rtl/tlp_replay_chk.sv
module tlp_replay_chk
  import tlp_replay_pkg::*;
(
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic outValid,
  input logic outReady,
  input seq_t outSeq,
  input logic evtValid,
  input logic replayOn
);
  seq_t newCnt;

  always_ff @(posedge clk) begin
    if (!rstN) newCnt <= '0;
    else if (inValid && inReady) newCnt <= newCnt + 1'b1;
  end

  // R7
  replay_blocks_input_chk: assert property (@(posedge clk) disable iff (!rstN)
    replayOn |-> !inReady);

  // R1
  new_seq_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (outSeq == newCnt));

  // R2
  new_pkt_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |-> (outValid && outReady));

  // R5
  replay_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (replayOn && !outReady && !evtValid) |=> (replayOn && $stable(outSeq)));

  // R5
  replay_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (replayOn && outReady && !evtValid) |=>
      (!replayOn || (outSeq == seq_t'($past(outSeq) + 1'b1))));
endmodule

bind tlp_replay_buf tlp_replay_chk uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .outValid(outValid), .outReady(outReady), .outSeq(outSeq),
  .evtValid(evtValid), .replayOn(replayOn)
);

// File: tb/tb_tlp_replay_buf.sv
module tb_tlp_replay_buf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int TIMEOUT = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [31:0] inBody = '0;
  logic outReady = 1'b1;
  logic evtValid = 1'b0;
  logic evtNak = 1'b0;
  logic [11:0] evtSeq = '0;
  logic inReady, outValid;
  logic [11:0] outSeq;
  logic [31:0] outBody, outCrc;

  int nChecks = 0;
  int nFail = 0;
  logic [11:0] expSeq = '0;
  logic [31:0] sentBody [4096];

  always #(CLK_PERIOD/2) clk = ~clk;

  tlp_replay_buf #(.DATA_W(32), .DEPTH(DEPTH), .TIMEOUT(TIMEOUT)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inBody(inBody), .outValid(outValid), .outReady(outReady),
    .outSeq(outSeq), .outBody(outBody), .outCrc(outCrc),
    .evtValid(evtValid), .evtNak(evtNak), .evtSeq(evtSeq)
  );

  function automatic logic [31:0] refCrc(input logic [11:0] s, input logic [31:0] b);
    logic [47:0] m;
    logic [31:0] c;
    m = {4'b0000, s, b};
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      if (c[31] != m[47-i]) c = (c << 1) ^ 32'h04C11DB7;
      else c = c << 1;
    end
    return ~c;
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  task automatic sendPkt(input logic [31:0] body);
    @(negedge clk);
    inValid = 1'b1;
    inBody = body;
    #1;
    while (!inReady) begin
      @(negedge clk);
      #1;
    end
    chk("R2", "outValid on accept", 64'(outValid), 64'd1);
    chk("R2", "passthrough body", 64'(outBody), 64'(body));
    chk("R1", "new seq", 64'(outSeq), 64'(expSeq));
    chk("R3", "crc new", 64'(outCrc), 64'(refCrc(expSeq, body)));
    @(posedge clk);
    #1;
    inValid = 1'b0;
    sentBody[expSeq] = body;
    expSeq = expSeq + 1'b1;
  endtask

  task automatic sendEvt(input logic nak, input logic [11:0] s);
    @(negedge clk);
    evtValid = 1'b1;
    evtNak = nak;
    evtSeq = s;
    @(posedge clk);
    #1;
    evtValid = 1'b0;
  endtask

  task automatic collectReplay(input logic [11:0] first, input int n, input string req);
    for (int k = 0; k < n; k++) begin
      logic [11:0] s;
      s = first + 12'(k);
      chk(req, "replay valid", 64'(outValid), 64'd1);
      chk(req, "replay seq", 64'(outSeq), 64'(s));
      chk(req, "replay body", 64'(outBody), 64'(sentBody[s]));
      chk("R3", "crc replay", 64'(outCrc), 64'(refCrc(s, sentBody[s])));
      chk("R7", "input blocked in replay", 64'(inReady), 64'd0);
      @(posedge clk);
      #1;
    end
    chk(req, "replay ended", 64'(outValid), 64'd0);
  endtask

  task automatic testReset();
    chk("R10", "outValid after reset", 64'(outValid), 64'd0);
    chk("R10", "inReady after reset", 64'(inReady), 64'd1);
  endtask

  task automatic testFirstSends();
    sendPkt(32'hA5A5_0001);
    sendPkt(32'h1234_5678);
    sendPkt(32'hFFFF_0000);
  endtask

  task automatic testNakStall();
    sendEvt(1'b1, 12'd0);
    outReady = 1'b0;
    #1;
    chk("R2", "inReady low when outReady low", 64'(inReady), 64'd0);
    chk("R5", "replay starts at oldest", 64'(outSeq), 64'd1);
    for (int k = 0; k < 2; k++) begin
      @(posedge clk);
      #1;
      chk("R5", "hold under stall", 64'(outSeq), 64'd1);
      chk("R5", "valid under stall", 64'(outValid), 64'd1);
    end
    outReady = 1'b1;
    #1;
    collectReplay(12'd1, 2, "R5");
  endtask

  task automatic testAckEmpty();
    int seen;
    seen = 0;
    sendEvt(1'b0, 12'd2);
    chk("R4", "ready after full ack", 64'(inReady), 64'd1);
    for (int k = 0; k < 2*TIMEOUT; k++) begin
      @(posedge clk);
      #1;
      if (outValid) seen++;
    end
    chk("R9", "no replay when empty", 64'(seen), 64'd0);
  endtask

  task automatic testFillAndTimer();
    int n;
    for (int k = 0; k < DEPTH; k++) sendPkt(32'hC000_0000 + 32'(k * 7));
    chk("R7", "inReady low when full", 64'(inReady), 64'd0);
    chk("R4", "acked slots reused", 64'(expSeq), 64'd11);
    n = 0;
    while (!outValid && n < 4*TIMEOUT) begin
      @(posedge clk);
      #1;
      n++;
    end
    chk("R6", "timer replay latency", 64'(n), 64'(TIMEOUT));
    collectReplay(12'd3, DEPTH, "R6");
  endtask

  task automatic testIgnored();
    sendEvt(1'b0, expSeq + 12'd100);
    chk("R8", "far ack ignored", 64'(inReady), 64'd0);
    sendEvt(1'b0, 12'd2);
    chk("R8", "stale ack ignored", 64'(inReady), 64'd0);
    sendEvt(1'b1, 12'd4090);
    chk("R8", "far nak no replay", 64'(outValid), 64'd0);
    chk("R8", "far nak no free", 64'(inReady), 64'd0);
  endtask

  task automatic testPartialAck();
    sendEvt(1'b0, 12'd6);
    chk("R4", "partial ack frees", 64'(inReady), 64'd1);
    for (int k = 0; k < 4; k++) sendPkt(32'h5EED_0000 + 32'(k));
    chk("R4", "exactly four freed", 64'(inReady), 64'd0);
    sendEvt(1'b1, 12'd10);
    collectReplay(12'd11, 4, "R5");
    sendEvt(1'b0, 12'd14);
    chk("R4", "all freed", 64'(inReady), 64'd1);
  endtask

  task automatic testWrap();
    while (expSeq != 12'd3) begin
      logic [11:0] s;
      s = expSeq;
      sendPkt({20'hBEEF0, s});
      sendEvt(1'b0, s);
    end
    chk("R1", "sequence wrapped", 64'(expSeq), 64'd3);
    chk("R4", "ack across wrap frees", 64'(inReady), 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rstN = 1'b1;
    testReset();
    testFirstSends();
    testNakStall();
    testAckEmpty();
    testFillAndTimer();
    testIgnored();
    testPartialAck();
    testWrap();
    summary();
  end
endmodule